// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable two-wire (I2C) slave that behaves like a 128 x 8 serial EEPROM. It runs on a system clock that is much faster than the bus clock. SCL and SDA pass through two-flop synchronisers. The block finds START, repeated START and STOP on the synchronised lines, and answers one 7-bit device code. It pulls SDA low through an output-enable, so the pad is open-drain.

Writes take a word address and then one or more data bytes. The low three address bits wrap inside an 8-byte page. After a STOP that ends a write, a timed busy period follows. During that period the slave does not answer its device code, so a master can poll it until it replies. All reads use one address counter. That counter increments after each byte sent and rolls over at the top of memory. A random read loads the counter with a dummy write followed by a repeated START. A write-control input held low blocks all writes to the array.

Top module: `eep_slave`

## Requirements
- R1: After reset, sda_oe_o and busy_o are 0.
- R2: The device code is 7'b1010000, sent MSB first, followed by the R/W bit (1 = read). The code byte is therefore 0xA0 for a write and 0xA1 for a read. A matching code is acknowledged. Any other code gets no acknowledge, and the slave ignores the bus until the next START.
- R3: A byte that has never been written reads as 0xFF.
- R4: A write is the code byte 0xA0, then a word address, then data. Only bits 6:0 of the word address are used. Data written this way is returned by a later random read of the same address.
- R5: A current-address read (START, then 0xA1) returns the byte that follows the last byte read.
- R6: While the master acknowledges, consecutive bytes are sent. After address 0x7F the next byte comes from address 0x00.
- R7: Every data byte of a page write is acknowledged. After each byte, address bits 2:0 increment modulo 8 and bits 6:3 stay fixed.
- R8: While wc_i is 0, data bytes are still acknowledged, but memory does not change and busy_o stays 0.
- R9: A STOP that ends a transfer which wrote at least one byte sets busy_o for WR_CYCLES clocks. During that time the device code is not acknowledged. Afterwards it is acknowledged again.
- R10: After the master NACKs a read byte, the slave releases SDA. It stays released on further SCL clocks until the next START.
- R11: sda_oe_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the pad |
| wc_i | input | 1 | Write control, 0 blocks writes |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The hardest state to reach is the end of a page write that has wrapped inside its page, followed by a read that runs across the top of memory. These can only be reached through complete bus transfers. The bench therefore issues a full 8-byte page write that starts two bytes before the page boundary. It then does random reads that start at 0x7E, after first writing both 0x7F and 0x00. Busy polling is reached by issuing a device code straight after the write STOP and repeating it until the slave acknowledges. A reference memory in the bench supplies every expected byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } st_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d_i[gi];
        s2 <= s1;
      end
    end
    assign q_o[gi] = s2;
  end
endmodule

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int unsigned CYCLES = 1000,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ID    = 7'b1010000,
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned PAGE      = 8,
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_oe_o,
  output logic busy_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = $clog2(PAGE);

  logic [1:0] sync_q;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  eep_sync #(.N(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  eep_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  st_e             st_q;
  logic [3:0]      bit_cnt_q;
  logic [BYTE_W-1:0] sr_q, tx_q;
  logic [AW-1:0]   ptr_q, waddr_q, rd_addr_q;
  logic [BYTE_W-1:0] wdata_q, rdata;
  logic            rw_q, wrote_q, m_ack_q, oe_q;
  logic            mem_we_q, wr_go_q, rd_pulse_q;
  logic            busy;

  eep_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we_q), .waddr_i(waddr_q), .wdata_i(wdata_q),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  eep_busy_timer #(.CYCLES(WR_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(wr_go_q), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      sr_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      rd_addr_q  <= '0;
      rw_q       <= 1'b0;
      wrote_q    <= 1'b0;
      m_ack_q    <= 1'b0;
      oe_q       <= 1'b0;
      mem_we_q   <= 1'b0;
      wr_go_q    <= 1'b0;
      rd_pulse_q <= 1'b0;
    end else begin
      mem_we_q   <= 1'b0;
      wr_go_q    <= 1'b0;
      rd_pulse_q <= 1'b0;
      if (start_det) begin
        st_q      <= ST_DEV;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_det) begin
        st_q    <= ST_IDLE;
        oe_q    <= 1'b0;
        wr_go_q <= wrote_q;
        wrote_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_DEV, ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sr_q      <= {sr_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == 4'd8) begin
              if (st_q == ST_DEV) begin
                if (sr_q[7:1] == DEV_ID && !busy) begin
                  oe_q <= 1'b1;
                  rw_q <= sr_q[0];
                  st_q <= ST_DEV_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_ADDR) begin
                oe_q  <= 1'b1;
                ptr_q <= sr_q[AW-1:0];
                st_q  <= ST_ADDR_ACK;
              end else begin
                oe_q <= 1'b1;
                st_q <= ST_WR_ACK;
                if (wc_i) begin
                  mem_we_q <= 1'b1;
                  waddr_q  <= ptr_q;
                  wdata_q  <= sr_q;
                  wrote_q  <= 1'b1;
                end
                // page roll: only the low bits advance
                ptr_q <= {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (rw_q) begin
                tx_q       <= rdata;
                oe_q       <= ~rdata[7];
                rd_addr_q  <= ptr_q;
                rd_pulse_q <= 1'b1;
                ptr_q      <= ptr_q + 1'b1;
                st_q       <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              st_q      <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                m_ack_q <= 1'b0;
                st_q    <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              m_ack_q <= ~sda_s;
            end else if (scl_fall) begin
              bit_cnt_q <= '0;
              if (m_ack_q) begin
                tx_q       <= rdata;
                oe_q       <= ~rdata[7];
                rd_addr_q  <= ptr_q;
                rd_pulse_q <= 1'b1;
                ptr_q      <= ptr_q + 1'b1;
                st_q       <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = busy;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          busy_o,
  input logic          start_det,
  input logic          mem_we,
  input logic [AW-1:0] waddr,
  input logic          rd_pulse,
  input logic [AW-1:0] rd_addr
);
  logic          w_have, r_have;
  logic [AW-1:0] w_prev, r_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_have <= 1'b0;
      r_have <= 1'b0;
      w_prev <= '0;
      r_prev <= '0;
    end else begin
      if (start_det) begin
        w_have <= 1'b0;
        r_have <= 1'b0;
      end else begin
        if (mem_we) begin
          w_have <= 1'b1;
          w_prev <= waddr;
        end
        if (rd_pulse) begin
          r_have <= 1'b1;
          r_prev <= rd_addr;
        end
      end
    end
  end

  a_r11_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  a_r9_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  a_r7_page_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && w_have) |-> (waddr[AW-1:PW] == w_prev[AW-1:PW] &&
                            waddr[PW-1:0] == PW'(w_prev[PW-1:0] + 1'b1)));

  a_r6_read_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pulse && r_have) |-> rd_addr == AW'(r_prev + 1'b1));
endmodule

bind eep_slave eep_slave_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .start_det(start_det), .mem_we(mem_we_q),
  .waddr(waddr_q), .rd_pulse(rd_pulse_q), .rd_addr(rd_addr_q)
);

// File: tb/sim_eep_slave.sv
module sim_eep_slave;
  localparam int H = 8;
  localparam int WRC = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wc = 1'b1;
  logic sda_oe, busy;
  wire  sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, glitch = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] rb [16];

  always #2 clk = ~clk;

  eep_slave #(.WR_CYCLES(WRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .wc_i(wc), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart;
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H);
  endtask

  task automatic bstop;
    m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(H);
    end
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H / 2);
    ack = ~sda_line; tick(H / 2); m_scl = 1'b0; tick(H);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    logic s1;
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(H); m_scl = 1'b1; tick(2); s1 = sda_line; tick(H / 2 - 2);
      b = {b[6:0], sda_line}; tick(H / 2 - 1);
      if (sda_line !== s1) glitch++;
      tick(1); m_scl = 1'b0;
    end
    m_sda = ~mack; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(H);
    m_sda = 1'b1;
  endtask

  task automatic write_bytes(input logic [7:0] a, input logic [7:0] d0, input int n);
    logic ack;
    bstart;
    wbyte(8'hA0, ack); chk("R2 write code ack", ack, 1);
    wbyte(a, ack);     chk("R4 addr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(d0 + 8'(i), ack);
      chk("R7 data ack", ack, 1);
      if (wc) exp_mem[{a[6:3], 3'(a[2:0] + 3'(i))}] = d0 + 8'(i);
    end
    bstop;
  endtask

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    for (int k = 0; k < 100; k++) begin
      bstart; wbyte(8'hA0, ack); bstop;
      if (ack) break;
      polls++;
    end
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n);
    logic ack;
    bstart;
    wbyte(8'hA0, ack); wbyte(a, ack);
    bstart;
    wbyte(8'hA1, ack); chk("R2 read code ack", ack, 1);
    for (int i = 0; i < n; i++) rbyte(i < n - 1, rb[i]);
  endtask

  task automatic t_reset;
    chk("R1 oe after reset", sda_oe, 0);
    chk("R1 busy after reset", busy, 0);
  endtask

  task automatic t_devsel;
    logic ack;
    bstart; wbyte(8'hA6, ack); chk("R2 wrong code nack", ack, 0);
    wbyte(8'hA0, ack); chk("R2 ignored until START", ack, 0);
    bstop;
    bstart; wbyte(8'hA0, ack); chk("R2 match ack", ack, 1); bstop;
  endtask

  task automatic t_blank;
    rd_rand(8'h10, 1); bstop;
    chk("R3 blank byte", rb[0], 8'hFF);
  endtask

  task automatic t_byte_write;
    int polls;
    write_bytes(8'h10, 8'h3C, 1);
    chk("R9 busy after write", busy, 1);
    wait_ready(polls);
    chk("R9 nack while busy", polls > 0, 1);
    chk("R9 ready again", polls < 100, 1);
    chk("R9 busy cleared", busy, 0);
    rd_rand(8'h90, 1); bstop;
    chk("R4 readback (addr bit7 ignored)", rb[0], 8'h3C);
  endtask

  task automatic t_page;
    int polls;
    write_bytes(8'h26, 8'h80, 8);
    wait_ready(polls);
    rd_rand(8'h20, 8); bstop;
    for (int i = 0; i < 8; i++) chk("R7 page wrap", rb[i], exp_mem[8'h20 + i]);
    bstart;
    begin
      logic ack;
      wbyte(8'hA1, ack);
      rbyte(1'b1, rb[0]); rbyte(1'b0, rb[1]);
    end
    bstop;
    chk("R5 current read", rb[0], exp_mem[8'h28]);
    chk("R5 current read next", rb[1], exp_mem[8'h29]);
  endtask

  task automatic t_wrap;
    int polls;
    write_bytes(8'h7F, 8'h5A, 1); wait_ready(polls);
    write_bytes(8'h00, 8'hA5, 1); wait_ready(polls);
    rd_rand(8'h7E, 3); bstop;
    chk("R6 seq 7E", rb[0], exp_mem[8'h7E]);
    chk("R6 seq 7F", rb[1], 8'h5A);
    chk("R6 rollover 00", rb[2], 8'hA5);
  endtask

  task automatic t_wc;
    wc = 1'b0;
    write_bytes(8'h10, 8'h99, 2);
    chk("R8 no busy when inhibited", busy, 0);
    wc = 1'b1;
    rd_rand(8'h10, 2); bstop;
    chk("R8 memory unchanged", rb[0], 8'h3C);
    chk("R8 memory unchanged next", rb[1], exp_mem[8'h11]);
  endtask

  task automatic t_nack_end;
    int lows = 0;
    logic ack;
    rd_rand(8'h20, 1);
    for (int i = 0; i < 9; i++) begin
      tick(H); m_scl = 1'b1; tick(H / 2);
      if (sda_line !== 1'b1 || sda_oe !== 1'b0) lows++;
      tick(H / 2); m_scl = 1'b0;
    end
    tick(H);
    chk("R10 released after nack", lows, 0);
    bstop;
    bstart; wbyte(8'hA0, ack); chk("R10 answers after START", ack, 1); bstop;
    chk("R11 sda stable while scl high", glitch, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_devsel;
    t_blank;
    t_byte_write;
    t_page;
    t_wrap;
    t_wc;
    t_nack_end;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule